// File: doc/BRIEF.md
# Masked Internal Control Register File

This block holds a bank of privileged processor control registers behind a single port. The port takes a register index, a read strobe, a write strobe and write data. Each index has its own access policy. Some registers are full-width scratch storage. Some keep only selected bit fields of a write. A few clear themselves on any write. A group can only be read, and another group can only be written. Two indices act as command strobes: a write to either one sends a one-cycle pulse to a neighbouring address-translation buffer.

One index is a cycle counter. Its upper half is stored and can be written. Its lower half is a live count that starts at zero at reset and advances by one every clock.

Reads are combinational: `rdata` reflects the addressed register in the same cycle as `rd_en`. A write lands at the clock edge where `wr_en` is sampled. The access-error flag and the command pulses are registered, so each is high for exactly the one cycle after the access that caused it.

Top module: `icr_file`

## Requirements
- R1: After reset, index 8 (code base) holds the BASE_RESET parameter (default 0x10000), index 9 (machine control) holds 0x6, index 7 (scratch) holds the `cpu_id` input zero-extended, and every other stored register reads 0.
- R2: Indices 0 to 7 and 9 are full-width storage. A legal write to one of them is read back unchanged on any later cycle.
- R3: A write to index 10 (exception address) stores the data with bit 1 forced to zero.
- R4: Writes to field registers keep only their mask:
  - 11 and 12: 0xf
  - 13 and 14: 0x18
  - 16: 0x7fff0
  - 17: 0xffffff0300
  - 18 and 19: 0xffffffffc0000000
  - 20: 0x1ffb
  - 21 and 22: 0x3f
  - 23: 0x7f0
  - 24: 0xfe00000000000000
- R5: Any write to index 25 or 26 (exception summary, exception mask) leaves that register at zero, whatever the data.
- R6: A read of index 27 (cycle counter) returns the written upper 32 bits together with the live count in the low 32 bits. Two reads one cycle apart differ by exactly 1 in the low half.
- R7: A write to a read-only index (28 to 31) raises `acc_err` in the next cycle and leaves the register unchanged; those registers read 0.
- R8: A read of a write-only index (15, 32 to 37) raises `acc_err` in the next cycle and returns `rdata` = 0; writes to those indices raise no error.
- R9: A write or read of an unmapped index (38 to 63) raises `acc_err` in the next cycle and changes no register.
- R10: A write to index 36 pulses `flush_all` and a write to index 37 pulses `flush_asn`, each high for exactly the one cycle after the write.
- R11: A legal access, or a cycle with no access, leaves `acc_err` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_id | input | 8 | Processor identifier, loaded into scratch index 7 at reset |
| idx | input | 6 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, combinational, 0 when not reading or on an illegal read |
| acc_err | output | 1 | One-cycle access-error pulse, the cycle after the illegal access |
| flush_all | output | 1 | One-cycle pulse: invalidate every translation entry |
| flush_asn | output | 1 | One-cycle pulse: invalidate the current process's translation entries |

## Verification
Read data is due in the same cycle as the read strobe. The bench drives each read on a falling edge and samples `rdata` a nanosecond later, before the next rising edge. A write becomes visible from the cycle after its strobe is sampled. The error flag and the flush pulses are due in the one cycle after the access, so the bench samples them on the falling edge that follows that rising edge. It also samples them once more a cycle later to confirm the pulse has ended. The live low half of the cycle counter is checked through the difference between back-to-back reads, not an absolute count.

// File: rtl/icr_pkg.sv
package icr_pkg;

    localparam int IW     = 6;
    localparam int DW     = 64;
    localparam int NSTORE = 32;
    localparam int SW     = $clog2(NSTORE);
    localparam int CC_LO  = 32;

    typedef enum logic [2:0] {
        K_RW,
        K_RO,
        K_WO,
        K_STROBE,
        K_CC,
        K_NONE
    } kind_t;

    localparam logic [IW-1:0] IX_SCR_CPU   = 6'd7;
    localparam logic [IW-1:0] IX_BASE      = 6'd8;
    localparam logic [IW-1:0] IX_MCTL      = 6'd9;
    localparam logic [IW-1:0] IX_EXC       = 6'd10;
    localparam logic [IW-1:0] IX_AST_REQ   = 6'd11;
    localparam logic [IW-1:0] IX_AST_EN    = 6'd12;
    localparam logic [IW-1:0] IX_IMODE     = 6'd13;
    localparam logic [IW-1:0] IX_DMODE     = 6'd14;
    localparam logic [IW-1:0] IX_ALTMODE   = 6'd15;
    localparam logic [IW-1:0] IX_SWINT     = 6'd16;
    localparam logic [IW-1:0] IX_ICTL      = 6'd17;
    localparam logic [IW-1:0] IX_IVPT      = 6'd18;
    localparam logic [IW-1:0] IX_DVPT      = 6'd19;
    localparam logic [IW-1:0] IX_DCTEST    = 6'd20;
    localparam logic [IW-1:0] IX_DCMODE    = 6'd21;
    localparam logic [IW-1:0] IX_MISSMODE  = 6'd22;
    localparam logic [IW-1:0] IX_IASN      = 6'd23;
    localparam logic [IW-1:0] IX_DASN      = 6'd24;
    localparam logic [IW-1:0] IX_EXSUM     = 6'd25;
    localparam logic [IW-1:0] IX_EXMASK    = 6'd26;
    localparam logic [IW-1:0] IX_CYC       = 6'd27;
    localparam logic [IW-1:0] IX_RO_FIRST  = 6'd28;
    localparam logic [IW-1:0] IX_RO_LAST   = 6'd31;
    localparam logic [IW-1:0] IX_WO_FIRST  = 6'd32;
    localparam logic [IW-1:0] IX_WO_LAST   = 6'd35;
    localparam logic [IW-1:0] IX_FLUSH_ALL = 6'd36;
    localparam logic [IW-1:0] IX_FLUSH_ASN = 6'd37;

    function automatic kind_t reg_kind(input logic [IW-1:0] i);
        if (i == IX_ALTMODE)                           return K_WO;
        else if (i <= IX_EXMASK)                       return K_RW;
        else if (i == IX_CYC)                          return K_CC;
        else if (i >= IX_RO_FIRST && i <= IX_RO_LAST)  return K_RO;
        else if (i >= IX_WO_FIRST && i <= IX_WO_LAST)  return K_WO;
        else if (i == IX_FLUSH_ALL || i == IX_FLUSH_ASN) return K_STROBE;
        else                                           return K_NONE;
    endfunction

    function automatic logic [DW-1:0] keep_mask(input logic [IW-1:0] i);
        logic [DW-1:0] m;
        unique case (i)
            IX_EXC:                      m = ~64'h2;
            IX_AST_REQ, IX_AST_EN:       m = 64'hf;
            IX_IMODE, IX_DMODE,
            IX_ALTMODE:                  m = 64'h18;
            IX_SWINT:                    m = 64'h7fff0;
            IX_ICTL:                     m = 64'hff_ffff_0300;
            IX_IVPT, IX_DVPT:            m = 64'hffff_ffff_c000_0000;
            IX_DCTEST:                   m = 64'h1ffb;
            IX_DCMODE, IX_MISSMODE:      m = 64'h3f;
            IX_IASN:                     m = 64'h7f0;
            IX_DASN:                     m = 64'hfe00_0000_0000_0000;
            IX_EXSUM, IX_EXMASK:         m = '0;
            default:                     m = '1;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/icr_decode.sv
module icr_decode
    import icr_pkg::*;
(
    input  logic [IW-1:0] idx,
    input  logic          rd_en,
    input  logic          wr_en,
    output kind_t         kind,
    output logic [DW-1:0] mask,
    output logic          store_we,
    output logic          illegal
);
    always_comb begin
        kind     = reg_kind(idx);
        mask     = keep_mask(idx);
        store_we = wr_en && (int'(idx) < NSTORE) &&
                   (kind == K_RW || kind == K_WO || kind == K_CC);
        illegal  = (wr_en && (kind == K_RO || kind == K_NONE)) ||
                   (rd_en && (kind == K_WO || kind == K_STROBE || kind == K_NONE));
    end
endmodule

// File: rtl/icr_cell.sv
module icr_cell #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic         we,
    input  logic [W-1:0] wd,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= rst_val;
        else if (we) q <= wd;
    end
endmodule

// File: rtl/icr_livecnt.sv
module icr_livecnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/icr_file.sv
module icr_file
    import icr_pkg::*;
#(
    parameter logic [63:0] BASE_RESET = 64'h0000_0000_0001_0000,
    parameter int          CPU_ID_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CPU_ID_W-1:0] cpu_id,
    input  logic [5:0]          idx,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [63:0]         wdata,
    output logic [63:0]         rdata,
    output logic                acc_err,
    output logic                flush_all,
    output logic                flush_asn
);
    kind_t         kind;
    logic [DW-1:0] mask;
    logic          store_we;
    logic          illegal;
    logic [DW-1:0] q [NSTORE];
    logic [CC_LO-1:0] live;
    logic [DW-1:0] stored_word;

    icr_decode u_dec (
        .idx      (idx),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .kind     (kind),
        .mask     (mask),
        .store_we (store_we),
        .illegal  (illegal)
    );

    icr_livecnt #(.W(CC_LO)) u_live (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt   (live)
    );

    for (genvar g = 0; g < NSTORE; g++) begin : g_reg
        logic [DW-1:0] rv;
        if (g == int'(IX_BASE)) begin : g_base
            assign rv = BASE_RESET;
        end else if (g == int'(IX_MCTL)) begin : g_mctl
            assign rv = 64'h6;
        end else if (g == int'(IX_SCR_CPU)) begin : g_cpu
            assign rv = {{(DW-CPU_ID_W){1'b0}}, cpu_id};
        end else begin : g_zero
            assign rv = '0;
        end
        icr_cell #(.W(DW)) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .rst_val (rv),
            .we      (store_we && (idx[SW-1:0] == SW'(g))),
            .wd      (wdata & mask),
            .q       (q[g])
        );
    end

    always_comb begin
        stored_word = (int'(idx) < NSTORE) ? q[idx[SW-1:0]] : '0;
        rdata = '0;
        if (rd_en) begin
            unique case (kind)
                K_RW, K_RO: rdata = stored_word;
                K_CC:       rdata = {stored_word[DW-1:CC_LO], live};
                default:    rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_err   <= 1'b0;
            flush_all <= 1'b0;
            flush_asn <= 1'b0;
        end else begin
            acc_err   <= illegal;
            flush_all <= wr_en && (idx == IX_FLUSH_ALL);
            flush_asn <= wr_en && (idx == IX_FLUSH_ASN);
        end
    end
endmodule

// File: rtl/icr_file_chk.sv
module icr_file_chk
    import icr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [5:0]  idx,
    input logic        rd_en,
    input logic        wr_en,
    input logic [63:0] rdata,
    input logic        acc_err,
    input logic        flush_all,
    input logic        flush_asn
);
    a_r10_flush_all: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_FLUSH_ALL) |=> flush_all);

    a_r10_flush_asn: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IX_FLUSH_ASN) |=> flush_asn);

    a_r10_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!flush_all && !flush_asn));

    a_r7_ro_write_err: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx >= IX_RO_FIRST && idx <= IX_RO_LAST) |=> acc_err);

    a_r9_unmapped_err: assert property (@(posedge clk) disable iff (!rst_n)
        ((wr_en || rd_en) && idx > IX_FLUSH_ASN) |=> acc_err);

    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !rd_en) |=> !acc_err);

    a_r3_exc_bit1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IX_EXC) |-> !rdata[1]);

    a_r8_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx >= IX_WO_FIRST) |-> (rdata == 64'h0));

    a_r6_cc_low_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && idx == IX_CYC && $past(rd_en && idx == IX_CYC) && $past(rst_n))
        |-> (rdata[31:0] == 32'($past(rdata[31:0]) + 32'd1)));
endmodule

bind icr_file icr_file_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .rdata     (rdata),
    .acc_err   (acc_err),
    .flush_all (flush_all),
    .flush_asn (flush_asn)
);

// File: tb/icr_file_bench.sv
`timescale 1ns/1ps
module icr_file_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_id = 8'h5a;
    logic [5:0]  idx = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        acc_err, flush_all, flush_asn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    icr_file u_icr_file (
        .clk(clk), .rst_n(rst_n), .cpu_id(cpu_id), .idx(idx),
        .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
        .acc_err(acc_err), .flush_all(flush_all), .flush_asn(flush_asn)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // write; returns err and pulses seen one cycle after
    task automatic wr(input logic [5:0] i, input logic [63:0] d,
                      output logic err, output logic fa, output logic fp);
        @(negedge clk);
        idx = i; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        err = acc_err; fa = flush_all; fp = flush_asn;
    endtask

    task automatic rd(input logic [5:0] i, output logic [63:0] d, output logic err);
        @(negedge clk);
        idx = i; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
        err = acc_err;
    endtask

    task automatic t_reset();
        logic [63:0] d; logic e;
        rd(6'd8, d, e);  check("R1 base", d, 64'h10000);
        rd(6'd9, d, e);  check("R1 mctl", d, 64'h6);
        rd(6'd7, d, e);  check("R1 cpu id", d, 64'h5a);
        rd(6'd3, d, e);  check("R1 scratch3", d, 64'h0);
        rd(6'd17, d, e); check("R1 ictl", d, 64'h0);
    endtask

    task automatic t_scratch();
        logic [63:0] d; logic e, fa, fp;
        wr(6'd0, 64'hdead_beef_0123_4567, e, fa, fp);
        check("R11 legal write no err", {63'd0, e}, 64'd0);
        wr(6'd9, 64'hffff_0000_ffff_0000, e, fa, fp);
        rd(6'd0, d, e);
        check("R2 scratch0", d, 64'hdead_beef_0123_4567);
        check("R11 legal read no err", {63'd0, e}, 64'd0);
        rd(6'd9, d, e);  check("R2 mctl", d, 64'hffff_0000_ffff_0000);
    endtask

    task automatic t_exc();
        logic [63:0] d; logic e, fa, fp;
        wr(6'd10, 64'hffff_ffff_ffff_ffff, e, fa, fp);
        rd(6'd10, d, e); check("R3 exc addr", d, 64'hffff_ffff_ffff_fffd);
        wr(6'd10, 64'h0000_0000_0000_1002, e, fa, fp);
        rd(6'd10, d, e); check("R3 exc addr bit1", d, 64'h1000);
    endtask

    task automatic t_masks();
        logic [5:0]  ix [15] = '{6'd11, 6'd12, 6'd13, 6'd14, 6'd16, 6'd17, 6'd18,
                                 6'd19, 6'd20, 6'd21, 6'd22, 6'd23, 6'd24, 6'd25, 6'd26};
        logic [63:0] mk [15] = '{64'hf, 64'hf, 64'h18, 64'h18, 64'h7fff0,
                                 64'hff_ffff_0300, 64'hffff_ffff_c000_0000,
                                 64'hffff_ffff_c000_0000, 64'h1ffb, 64'h3f, 64'h3f,
                                 64'h7f0, 64'hfe00_0000_0000_0000, 64'h0, 64'h0};
        logic [63:0] d; logic e, fa, fp;
        for (int k = 0; k < 15; k++) begin
            wr(ix[k], '1, e, fa, fp);
            rd(ix[k], d, e);
            check(k >= 13 ? "R5 clear on write" : "R4 field mask", d, mk[k]);
        end
    endtask

    task automatic t_cc();
        logic [63:0] d0, d1; logic e, fa, fp;
        wr(6'd27, 64'habcd_1234_ffff_ffff, e, fa, fp);
        @(negedge clk);
        idx = 6'd27; rd_en = 1'b1;
        #1 d0 = rdata;
        @(negedge clk);
        #1 d1 = rdata;
        rd_en = 1'b0;
        check("R6 upper half", {32'd0, d1[63:32]}, 64'habcd_1234);
        check("R6 live step", {32'd0, 32'(d1[31:0] - d0[31:0])}, 64'd1);
    endtask

    task automatic t_ro();
        logic [63:0] d; logic e, fa, fp;
        wr(6'd29, '1, e, fa, fp);
        check("R7 ro write err", {63'd0, e}, 64'd1);
        rd(6'd29, d, e);
        check("R7 ro unchanged", d, 64'd0);
        check("R7 err ends", {63'd0, e}, 64'd0);
    endtask

    task automatic t_wo();
        logic [63:0] d; logic e, fa, fp;
        wr(6'd33, 64'h77, e, fa, fp);
        check("R8 wo write no err", {63'd0, e}, 64'd0);
        rd(6'd33, d, e);
        check("R8 wo read zero", d, 64'd0);
        check("R8 wo read err", {63'd0, e}, 64'd1);
        wr(6'd15, 64'hff, e, fa, fp);
        rd(6'd15, d, e);
        check("R8 alt mode read zero", d, 64'd0);
        check("R8 alt mode read err", {63'd0, e}, 64'd1);
    endtask

    task automatic t_unmapped();
        logic [63:0] d; logic e, fa, fp;
        wr(6'd2, 64'h1111_2222_3333_4444, e, fa, fp);
        wr(6'd42, 64'h5555, e, fa, fp);
        check("R9 unmapped write err", {63'd0, e}, 64'd1);
        rd(6'd2, d, e);
        check("R9 no effect", d, 64'h1111_2222_3333_4444);
        rd(6'd63, d, e);
        check("R9 unmapped read err", {63'd0, e}, 64'd1);
    endtask

    task automatic t_strobe();
        logic e, fa, fp;
        wr(6'd36, 64'h0, e, fa, fp);
        check("R10 flush_all pulse", {62'd0, fa, fp}, 64'b10);
        @(negedge clk);
        check("R10 flush_all ends", {62'd0, flush_all, flush_asn}, 64'b00);
        wr(6'd37, 64'h0, e, fa, fp);
        check("R10 flush_asn pulse", {62'd0, fa, fp}, 64'b01);
        check("R10 strobe no err", {63'd0, e}, 64'd0);
        @(negedge clk);
        check("R10 flush_asn ends", {62'd0, flush_all, flush_asn}, 64'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 reset err low", {63'd0, acc_err}, 64'd0);
        t_reset();
        t_scratch();
        t_exc();
        t_masks();
        t_cc();
        t_ro();
        t_wo();
        t_unmapped();
        t_strobe();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule